// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz tick enable into a programmable periodic event. A 4-bit rate code picks the interval. A 3-bit divider-control field decides whether the time base counts, stands still, or is held cleared. A single periodic-enable bit turns the whole generator on or off. Each time an interval completes, the block pulses a flag-set output and an interrupt-request output for one clock cycle. A surrounding register file or interrupt controller latches these pulses.

Software writes the two control bytes through data and write-strobe inputs, and the block keeps its own copy of the fields it uses. If the rate code is changed partway through an interval, the ticks already counted since the last event still count toward the new interval. If that count already meets or exceeds the new interval, one catch-up event follows on the next tick. Only one event is produced, however far the count has gone past the new interval.

Top module: `prd_rate_gen`

## Requirements
- R1: After reset the control byte A holds 0x26, so the rate code is 6 and the dividers run. Periodic enable is clear, so no pulse appears whatever the ticks do. Setting only the enable bit then gives a first event 32 ticks later.
- R2: The rate code is A[3:0]. Code 0 produces no events. Code 1 gives an interval of 128 ticks and code 2 gives 256 ticks. Codes 3 to 15 give 2^(code-1) ticks.
- R3: Only cycles with `tick_en` high advance the interval count. Idle cycles between ticks neither add to the count nor produce an event.
- R4: Periodic enable is bit 6 of control byte B. While it is clear, the interval counts as zero, no event occurs and the count is cleared. The other bits of B have no effect. Once the bit is set, the first event comes a full interval later.
- R5: The count advances only while A[6:4] is 3'b010 or lower. With A[6:5] = 2'b11 the count is held at zero, so a full interval follows the release. With any other value (3'b011, 3'b100, 3'b101) the count is frozen and resumes where it stopped.
- R6: A change of rate code keeps the ticks already counted. The event falls when the count reaches the new interval. If the count already meets or exceeds the new interval, exactly one event falls on the next tick, and full intervals follow it.
- R7: A write takes effect from the next cycle. A tick in the same cycle as a write is judged against the old settings.
- R8: `flag_set_o` and `irq_req_o` are single-cycle pulses. They appear in the cycle after the clock edge that samples the completing tick. `irq_req_o` is never high without `flag_set_o`.
- R9: Rewriting A with the same rate code and divider field, or rewriting B with the enable bit still set, leaves the running count undisturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 32768 Hz time-base tick |
| reg_a_wdata | input | 8 | Write data for control byte A: rate code in [3:0], divider control in [6:4], [7] ignored |
| reg_a_we | input | 1 | Write strobe for control byte A |
| reg_b_wdata | input | 8 | Write data for control byte B: periodic enable in [6] |
| reg_b_we | input | 1 | Write strobe for control byte B |
| flag_set_o | output | 1 | Pulse: the periodic flag is to be set |
| irq_req_o | output | 1 | Pulse: the periodic interrupt is to be raised |

## Verification
A wrong interval count shows at the ports only as a misplaced pulse. That can be as late as one full interval, which is 16384 ticks for code 15. For this reason, the bench measures the exact number of ticks from each event or write to the next pulse, rather than only counting pulses. A count that fails to clear under divider hold or enable-off shows as a short first interval after the release. A frozen count that clears by mistake shows as a long one. A decode error in the rate table or the divider field appears within one interval of the write that selects it.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned DIV_W  = 3;

  // Control byte A fields kept by the block (bit 7 is not stored)
  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [RATE_W-1:0] rate;
  } rate_ctl_t;

  // Interval in ticks for a rate code; 0 means no events
  function automatic int unsigned rate_period(input int unsigned code);
    if (code == 0)     return 0;
    else if (code < 3) return 32'd64 << code;
    else               return 32'd1 << (code - 1);
  endfunction

  // Dividers count when the control field is 3'b010 or lower
  function automatic logic div_running(input logic [DIV_W-1:0] div);
    return div <= 3'b010;
  endfunction

  // Dividers held cleared when the two upper bits are set
  function automatic logic div_held(input logic [DIV_W-1:0] div);
    return div[DIV_W-1 -: 2] == 2'b11;
  endfunction
endpackage

// File: rtl/prg_ctl_regs.sv
module prg_ctl_regs
  import prg_pkg::*;
#(
  parameter logic [7:0] RESET_A   = 8'h26,
  parameter logic       RESET_PIE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RATE_W+DIV_W-1:0]  a_wdata,
  input  logic                     a_we,
  input  logic                     pie_wbit,
  input  logic                     b_we,
  output rate_ctl_t                ctl_q,
  output logic                     pie_q
);
  localparam int unsigned CTL_W = RATE_W + DIV_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= rate_ctl_t'(RESET_A[CTL_W-1:0]);
      pie_q <= RESET_PIE;
    end else begin
      if (a_we) ctl_q <= rate_ctl_t'(a_wdata);
      if (b_we) pie_q <= pie_wbit;
    end
  end
endmodule

// File: rtl/prg_period_sel.sv
module prg_period_sel
  import prg_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic [RATE_W-1:0] rate,
  input  logic              pie,
  output logic [PER_W-1:0]  period,
  output logic              active
);
  localparam int unsigned CODES = 2 ** RATE_W;

  logic [PER_W-1:0] per_lut [CODES];

  for (genvar c = 0; c < CODES; c++) begin : g_lut
    assign per_lut[c] = PER_W'(rate_period(c));
  end

  assign period = pie ? per_lut[rate] : '0;
  assign active = (period != '0);
endmodule

// File: rtl/prg_elapsed_cnt.sv
module prg_elapsed_cnt #(
  parameter int unsigned TICK_W = 15,
  parameter int unsigned PER_W  = TICK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              running,
  input  logic              held,
  input  logic              active,
  input  logic [PER_W-1:0]  period,
  output logic [TICK_W-1:0] elapsed_q,
  output logic              fire
);
  logic [PER_W-1:0] nxt;
  logic             due;

  // Ticks since the last event, compared against whatever interval is current
  assign nxt  = PER_W'(elapsed_q) + PER_W'(1);
  assign due  = (nxt >= period);
  assign fire = active && running && tick_en && due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed_q <= '0;
    end else if (held || !active) begin
      elapsed_q <= '0;
    end else if (running && tick_en) begin
      elapsed_q <= due ? '0 : nxt[TICK_W-1:0];
    end
  end
endmodule

// File: rtl/prd_rate_gen.sv
module prd_rate_gen
  import prg_pkg::*;
#(
  parameter int unsigned TICK_W  = 15,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PIE_BIT = 6,
  parameter logic [7:0]  RESET_A = 8'h26,
  parameter logic [7:0]  RESET_B = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DATA_W-1:0] reg_a_wdata,
  input  logic              reg_a_we,
  input  logic [DATA_W-1:0] reg_b_wdata,
  input  logic              reg_b_we,
  output logic              flag_set_o,
  output logic              irq_req_o
);
  localparam int unsigned PER_W = TICK_W + 1;
  localparam int unsigned CTL_W = RATE_W + DIV_W;

  rate_ctl_t          ctl_q;
  logic               pie_q;
  logic               run_w;
  logic               held_w;
  logic [PER_W-1:0]   period_w;
  logic               active_w;
  logic [TICK_W-1:0]  elapsed_w;
  logic               fire_w;
  logic               unused_bits;

  // Bits of the write data that carry no field for this block
  assign unused_bits = reg_a_wdata[DATA_W-1]
                     ^ (^(reg_b_wdata & ~(DATA_W'(1) << PIE_BIT)));

  prg_ctl_regs #(
    .RESET_A   (RESET_A),
    .RESET_PIE (RESET_B[PIE_BIT])
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_wdata  (reg_a_wdata[CTL_W-1:0]),
    .a_we     (reg_a_we),
    .pie_wbit (reg_b_wdata[PIE_BIT]),
    .b_we     (reg_b_we),
    .ctl_q    (ctl_q),
    .pie_q    (pie_q)
  );

  assign run_w  = div_running(ctl_q.div);
  assign held_w = div_held(ctl_q.div);

  prg_period_sel #(.PER_W(PER_W)) sel_i (
    .rate   (ctl_q.rate),
    .pie    (pie_q),
    .period (period_w),
    .active (active_w)
  );

  prg_elapsed_cnt #(.TICK_W(TICK_W), .PER_W(PER_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .running   (run_w),
    .held      (held_w),
    .active    (active_w),
    .period    (period_w),
    .elapsed_q (elapsed_w),
    .fire      (fire_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_set_o <= 1'b0;
      irq_req_o  <= 1'b0;
    end else begin
      flag_set_o <= fire_w;
      irq_req_o  <= fire_w && pie_q;
    end
  end
endmodule

// File: rtl/prd_rate_gen_chk.sv
module prd_rate_gen_chk #(
  parameter int unsigned TICK_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              pie,
  input logic [3:0]        rate,
  input logic              running,
  input logic              held,
  input logic              active,
  input logic [TICK_W-1:0] elapsed,
  input logic              flag_set_o,
  input logic              irq_req_o
);
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> flag_set_o); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |=> !flag_set_o); // R8
  AST_FIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |-> $past(tick_en)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !held && active) |=> $stable(elapsed)); // R3
  AST_HELD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (elapsed == '0)); // R5
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !held && active) |=> $stable(elapsed)); // R5
  AST_PIE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pie |=> !flag_set_o); // R4
  AST_CODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 4'd0) |=> !flag_set_o); // R2
  AST_ZERO_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set_o |-> (elapsed == '0)); // R6
endmodule

bind prd_rate_gen prd_rate_gen_chk #(.TICK_W(TICK_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .pie        (pie_q),
  .rate       (ctl_q.rate),
  .running    (run_w),
  .held       (held_w),
  .active     (active_w),
  .elapsed    (elapsed_w),
  .flag_set_o (flag_set_o),
  .irq_req_o  (irq_req_o)
);

// File: tb/prd_rate_gen_tb_top.sv
module prd_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [7:0] a_wd, b_wd;
  logic       a_we, b_we;
  wire        flag, irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit last_fire;

  // Reference state, kept from the requirements
  logic [7:0] m_a, m_b;
  int         m_el;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  prd_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reg_a_wdata(a_wd), .reg_a_we(a_we),
    .reg_b_wdata(b_wd), .reg_b_we(b_we),
    .flag_set_o(flag), .irq_req_o(irq)
  );

  function automatic int ref_interval(input logic [7:0] a, input logic [7:0] b);
    if (!b[6]) return 0;
    case (a[3:0])
      4'd0:    return 0;
      4'd1:    return 128;
      4'd2:    return 256;
      default: return 2 ** (int'(a[3:0]) - 1);
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit wa, input logic [7:0] da,
                      input bit wb, input logic [7:0] db, input string tag);
    int  per;
    bit  exp_fire;
    bit  counts;
    bit  cleared;
    tick_en = tk; a_we = wa; a_wd = da; b_we = wb; b_wd = db;
    per     = ref_interval(m_a, m_b);
    cleared = (m_a[6:5] == 2'b11) || (per == 0);
    counts  = (m_a[6:4] <= 3'd2);
    exp_fire = 0;
    if (cleared) m_el = 0;
    else if (counts && tk) begin
      m_el = m_el + 1;
      if (m_el >= per) begin exp_fire = 1; m_el = 0; end
    end
    if (wa) m_a = da;
    if (wb) m_b = db;
    @(posedge clk);
    @(negedge clk);
    tick_en = 0; a_we = 0; b_we = 0;
    last_fire = flag;
    chk(flag == exp_fire, {tag, " flag"}, int'(flag), int'(exp_fire));
    chk(irq == exp_fire, {tag, " R8 irq"}, int'(irq), int'(exp_fire));
  endtask

  task automatic wr_a(input logic [7:0] d, input string tag);
    step(0, 1, d, 0, 8'h00, tag);
  endtask

  task automatic wr_b(input logic [7:0] d, input string tag);
    step(0, 0, 8'h00, 1, d, tag);
  endtask

  task automatic run_ticks(input int k, input string tag, output int fires);
    fires = 0;
    for (int i = 0; i < k; i++) begin
      step(1, 0, 8'h00, 0, 8'h00, tag);
      if (last_fire) fires++;
    end
  endtask

  task automatic measure(input int gap, input string tag, output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      step(1, 0, 8'h00, 0, 8'h00, tag);
      n++;
      if (last_fire) break;
      for (int g = 0; g < gap; g++) step(0, 0, 8'h00, 0, 8'h00, tag);
    end
  endtask

  initial begin
    wait (cyc >= 190000 || done);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int f;
    int codes [6] = '{1, 2, 3, 4, 9, 15};
    int lens  [6] = '{128, 256, 4, 8, 256, 16384};
    void'($urandom(32'd20240611));
    rst_n = 0; tick_en = 0; a_we = 0; b_we = 0; a_wd = 0; b_wd = 0;
    m_a = 8'h26; m_b = 8'h02; m_el = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    chk(flag == 0, "R1 reset flag", int'(flag), 0);
    chk(irq == 0, "R1 reset irq", int'(irq), 0);

    // R1: quiet after reset, default rate is 32 ticks
    run_ticks(100, "R1", f);   chk(f == 0, "R1 fires while disabled", f, 0);
    wr_b(8'h40, "R1");
    measure(0, "R1", n);       chk(n == 32, "R1 default interval", n, 32);
    measure(0, "R8", n);       chk(n == 32, "R8 repeat interval", n, 32);

    // R2: rate table
    for (int k = 0; k < 6; k++) begin
      wr_a(8'h20 | 8'(codes[k]), "R2");
      measure(0, "R2", n);     chk(n == lens[k], "R2 interval", n, lens[k]);
    end
    wr_a(8'h20, "R2");
    run_ticks(300, "R2", f);   chk(f == 0, "R2 code 0 quiet", f, 0);
    wr_a(8'h26, "R2");
    measure(0, "R2", n);       chk(n == 32, "R2 restart from code 0", n, 32);

    // R3: idle cycles between ticks do not count
    measure(2, "R3", n);       chk(n == 32, "R3 sparse ticks", n, 32);

    // R6: rate change mid-interval
    run_ticks(20, "R6", f);    chk(f == 0, "R6 pre", f, 0);
    wr_a(8'h24, "R6");
    measure(0, "R6", n);       chk(n == 1, "R6 overdue catch-up", n, 1);
    measure(0, "R6", n);       chk(n == 8, "R6 after catch-up", n, 8);
    wr_a(8'h26, "R6");
    run_ticks(5, "R6", f);
    wr_a(8'h24, "R6");
    measure(0, "R6", n);       chk(n == 3, "R6 shorter not reached", n, 3);
    wr_a(8'h26, "R6");
    run_ticks(20, "R6", f);
    wr_a(8'h27, "R6");
    measure(0, "R6", n);       chk(n == 44, "R6 longer interval", n, 44);

    // R9: same-value rewrites keep the count
    wr_a(8'h26, "R9");
    run_ticks(10, "R9", f);
    wr_a(8'h26, "R9");
    wr_b(8'h40, "R9");
    measure(0, "R9", n);       chk(n == 22, "R9 rewrite keeps count", n, 22);

    // R5: divider hold clears, stop freezes
    run_ticks(10, "R5", f);
    wr_a(8'h66, "R5");
    run_ticks(50, "R5", f);    chk(f == 0, "R5 held quiet", f, 0);
    wr_a(8'h26, "R5");
    measure(0, "R5", n);       chk(n == 32, "R5 full interval after hold", n, 32);
    run_ticks(10, "R5", f);
    wr_a(8'h36, "R5");
    run_ticks(50, "R5", f);    chk(f == 0, "R5 stopped quiet", f, 0);
    wr_a(8'h26, "R5");
    measure(0, "R5", n);       chk(n == 22, "R5 resume after stop", n, 22);

    // R4: enable bit off clears; other bits of B ignored
    run_ticks(10, "R4", f);
    wr_b(8'h00, "R4");
    run_ticks(50, "R4", f);    chk(f == 0, "R4 disabled quiet", f, 0);
    wr_b(8'hBF, "R4");
    run_ticks(50, "R4", f);    chk(f == 0, "R4 other bits ignored", f, 0);
    wr_b(8'h40, "R4");
    measure(0, "R4", n);       chk(n == 32, "R4 full interval after enable", n, 32);

    // R7: tick in the write cycle uses the old rate
    run_ticks(30, "R7", f);
    step(1, 1, 8'h24, 0, 8'h00, "R7");
    chk(last_fire == 0, "R7 write-cycle tick", int'(last_fire), 0);
    measure(0, "R7", n);       chk(n == 1, "R7 new rate next tick", n, 1);

    // Random mix against the reference (R6, R7)
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [2:0] dv;
      logic [3:0] rt;
      logic [7:0] db;
      r  = $urandom_range(0, 9);
      dv = (r < 7) ? 3'b010 : (r == 7) ? 3'b110 : (r == 8) ? 3'b011 : 3'b000;
      rt = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(3, 7));
      db = 8'($urandom) & 8'hBF;
      if ($urandom_range(0, 9) < 8) db = db | 8'h40;
      step(1'($urandom_range(0, 1)),
           $urandom_range(0, 19) == 0, {1'($urandom_range(0, 1)), dv, rt},
           $urandom_range(0, 49) == 0, db, "R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule